// File: doc/BRIEF.md
# Serial Register Access Host Controller

This block is the host side of a four-wire serial link to a register-based peripheral. The link has a chip select, a serial clock, a host-to-peripheral data line and a peripheral-to-host data line. A user asks for one register access with a single-cycle start request. The request carries the direction, a 6-bit register address, a byte count and up to three bytes of write data. The controller pulls chip select low and sends a command byte. It then either shifts out the data bytes or clocks in the reply bytes. Finally it releases chip select and pulses done. On a read, the reply is presented on the result bus in the same cycle as done.

Every timing minimum of the link is a parameter in nanoseconds. This covers chip-select setup and hold, the clock high and low widths, the long wait a read needs after its command byte, and the separate inter-byte gaps for writes and reads. Each minimum is converted to system-clock cycles by rounding up, so no count can come out short. The serial clock rests high whenever no bit is being clocked.

Top module: `serreg_host`

## Requirements
- R1: The first byte of every access is a command byte: bit 7 is 1 for a write and 0 for a read, bit 6 is 0, and bits 5..0 are the register address. It is sent bit 7 first.
- R2: After the command byte, a write sends exactly `nbytes` data bytes taken from the low end of `wdata`, the most significant of those bytes first and each byte bit 7 first. Bits of `wdata` above the requested bytes are not sent.
- R3: The host data line changes only together with a rising serial-clock edge. It is stable through every low phase and across every falling edge.
- R4: On a read, the host samples the peripheral data line at each falling edge of the data bytes. `rdata` holds the reply right-aligned, with bits above 8*`nbytes` at zero. After a write, `rdata` is zero.
- R5: The first falling clock edge comes at least T_CSS after chip select falls. Chip select stays low for at least T_CSH after the last falling edge.
- R6: Every serial-clock high phase lasts at least T_HI and every low phase lasts at least T_LO.
- R7: On a read, the clock stays high for at least T_RDWAIT between the end of the command byte and the first falling edge of the data.
- R8: Between consecutive bytes, the clock stays high for at least T_WRGAP on a write and at least T_RDGAP between data bytes of a read.
- R9: The serial clock is high whenever chip select is high. Chip select stays low for the whole command-plus-data access and is high after reset.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse, and `busy` falls in that same cycle. A start while busy is ignored: it neither starts nor changes an access.
- R11: A byte count of 0 is handled as a count of 1.
- R12: Each timing minimum becomes ceil(ns / CLK_NS) cycles, with at least 1 cycle. The low phase lasts exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Register address |
| nbytes | input | 2 | Data byte count 1..3 (0 acts as 1) |
| wdata | input | 24 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Read result, right-aligned, valid with done |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Host-to-peripheral data |
| miso | input | 1 | Peripheral-to-host data |

## Verification
The hardest case to reach is a start request that arrives in the middle of an access. It must leave that access's frame, timing and result untouched, and it must not trigger a second access afterwards. The bench first launches a single-byte write. After a fixed delay it raises start again with a different direction, address and count. It then compares the captured frame with the first request and confirms that chip select stays high afterwards. A timing monitor measures every clock phase against the minimums, using non-integer nanosecond parameters so that rounding down would show. A responder feeds the read replies bit by bit from the observed clock edges.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2,
    ST_TAIL = 2'd3
  } serreg_state_e;

  // ceiling conversion from nanoseconds to clock cycles, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [1:0] eff_count(input logic [1:0] n);
    return (n == 2'd0) ? 2'd1 : n;
  endfunction

  function automatic logic [7:0] cmd_byte(input logic wr, input logic [5:0] a);
    return {wr, 1'b0, a};
  endfunction

  // full outgoing frame, command byte on top, data left-packed beneath it
  function automatic logic [31:0] frame(input logic wr, input logic [5:0] a,
                                        input logic [1:0] n, input logic [23:0] d);
    logic [23:0] al;
    if (!wr) al = 24'h0;
    else begin
      case (n)
        2'd1:    al = {d[7:0], 16'h0};
        2'd2:    al = {d[15:0], 8'h0};
        default: al = d;
      endcase
    end
    return {cmd_byte(wr, a), al};
  endfunction

endpackage

// File: rtl/serreg_timer.sv
module serreg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/serreg_shift.sv
module serreg_shift #(
  parameter int TXW = 32,
  parameter int RXW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_val,
  input  logic           shift,
  input  logic           sample,
  input  logic           miso,
  output logic           mosi,
  output logic [RXW-1:0] rx
);
  logic [TXW-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load)       tx <= load_val;
      else if (shift) tx <= {tx[TXW-2:0], 1'b0};
      if (load)        rx <= '0;
      else if (sample) rx <= {rx[RXW-2:0], miso};
    end
  end

  assign mosi = tx[TXW-1];
endmodule

// File: rtl/serreg_host.sv
module serreg_host
  import serreg_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int T_CSS_NS    = 50,
  parameter int T_HI_NS     = 50,
  parameter int T_LO_NS     = 50,
  parameter int T_CSH_NS    = 100,
  parameter int T_RDWAIT_NS = 4000,
  parameter int T_WRGAP_NS  = 400,
  parameter int T_RDGAP_NS  = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic [5:0]  addr,
  input  logic [1:0]  nbytes,
  input  logic [23:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [23:0] rdata,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int C_HI    = ns2cyc(T_HI_NS, CLK_NS);
  localparam int C_LO    = ns2cyc(T_LO_NS, CLK_NS);
  localparam int C_CSS   = ns2cyc(T_CSS_NS, CLK_NS);
  localparam int C_CSH   = ns2cyc(T_CSH_NS, CLK_NS);
  localparam int C_FIRST = imax(C_CSS, C_HI);
  localparam int C_RDW   = imax(ns2cyc(T_RDWAIT_NS, CLK_NS), C_HI);
  localparam int C_WG    = imax(ns2cyc(T_WRGAP_NS, CLK_NS), C_HI);
  localparam int C_RG    = imax(ns2cyc(T_RDGAP_NS, CLK_NS), C_HI);
  localparam int C_TAIL  = imax(1, C_CSH - C_LO);
  localparam int C_MAX   = imax(imax(imax(C_FIRST, C_RDW), imax(C_WG, C_RG)),
                                imax(C_LO, C_TAIL));
  localparam int CW      = $clog2(C_MAX + 1);

  serreg_state_e state;
  logic [4:0]    rem;      // bits still to send after the current one
  logic          is_wr;
  logic [1:0]    nb;
  logic [23:0]   rx;
  logic          expired;
  logic [CW-1:0] load_val;
  logic [1:0]    n_eff;

  // named internal events, also watched by the checker
  logic ev_accept, ev_fall, ev_rise, ev_last, ev_end;
  logic byte_end, cmd_end, data_bit, do_sample, do_shift;

  assign n_eff     = eff_count(nbytes);
  assign ev_accept = start && (state == ST_IDLE);
  assign ev_fall   = (state == ST_HIGH) && expired;
  assign ev_rise   = (state == ST_LOW) && expired;
  assign ev_last   = ev_rise && (rem == 5'd0);
  assign ev_end    = (state == ST_TAIL) && expired;
  assign byte_end  = (rem[2:0] == 3'd0);
  assign cmd_end   = (rem == {nb, 3'b000});
  assign data_bit  = (rem < {nb, 3'b000});
  assign do_sample = ev_fall && !is_wr && data_bit;
  assign do_shift  = ev_rise && (rem != 5'd0);

  always_comb begin
    if (ev_accept)            load_val = CW'(C_FIRST - 1);
    else if (ev_fall)         load_val = CW'(C_LO - 1);
    else if (ev_last)         load_val = CW'(C_TAIL - 1);
    else if (cmd_end && !is_wr) load_val = CW'(C_RDW - 1);
    else if (byte_end)        load_val = is_wr ? CW'(C_WG - 1) : CW'(C_RG - 1);
    else                      load_val = CW'(C_HI - 1);
  end

  serreg_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept || ev_fall || ev_rise),
    .load_val (load_val),
    .expired  (expired)
  );

  serreg_shift #(.TXW(32), .RXW(24)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .load_val (frame(wr, addr, n_eff, wdata)),
    .shift    (do_shift),
    .sample   (do_sample),
    .miso     (miso),
    .mosi     (mosi),
    .rx       (rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      sclk  <= 1'b1;
      done  <= 1'b0;
      rdata <= '0;
      rem   <= '0;
      is_wr <= 1'b0;
      nb    <= 2'd1;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (ev_accept) begin
          cs_n  <= 1'b0;
          is_wr <= wr;
          nb    <= n_eff;
          rem   <= {n_eff, 3'b111};
          state <= ST_HIGH;
        end
        ST_HIGH: if (expired) begin
          sclk  <= 1'b0;
          state <= ST_LOW;
        end
        ST_LOW: if (expired) begin
          sclk <= 1'b1;
          if (rem == 5'd0) state <= ST_TAIL;
          else begin
            rem   <= rem - 5'd1;
            state <= ST_HIGH;
          end
        end
        ST_TAIL: if (expired) begin
          cs_n  <= 1'b1;
          done  <= 1'b1;
          rdata <= rx;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/serreg_host_chk.sv
module serreg_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic ev_fall,
  input logic ev_rise
);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_cs_within_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> $stable(mosi));

  assert_fall_from_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |-> sclk);

  assert_rise_from_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |-> !sclk);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_cs_from_idle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy)));
endmodule

bind serreg_host serreg_host_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .mosi    (mosi),
  .ev_fall (ev_fall),
  .ev_rise (ev_rise)
);

// File: tb/sim_serreg_host.sv
module sim_serreg_host;
  localparam int CLK = 10;
  localparam int P_CSS = 62, P_HI = 45, P_LO = 31, P_CSH = 95;
  localparam int P_RDW = 1003, P_WG = 205, P_RG = 52;

  // independent ceiling: whole cycles plus one if any remainder
  function automatic int up(input int ns);
    return ns / CLK + (((ns % CLK) != 0) ? 1 : 0);
  endfunction
  localparam int X_CSS = up(P_CSS), X_HI = up(P_HI), X_LO = up(P_LO), X_CSH = up(P_CSH);
  localparam int X_RDW = up(P_RDW), X_WG = up(P_WG), X_RG = up(P_RG);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr = 1'b0, miso = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] nbytes = '0;
  logic [23:0] wdata = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic [23:0] rdata;

  always #5 clk = ~clk;

  serreg_host #(.CLK_NS(CLK), .T_CSS_NS(P_CSS), .T_HI_NS(P_HI), .T_LO_NS(P_LO),
    .T_CSH_NS(P_CSH), .T_RDWAIT_NS(P_RDW), .T_WRGAP_NS(P_WG), .T_RDGAP_NS(P_RG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr), .nbytes(nbytes),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] resp_of(input logic [5:0] a);
    return {a, 2'b10, ~a, 2'b01, a ^ 6'h2A, 2'b11};
  endfunction
  function automatic logic [23:0] mask_of(input int n);
    return (n == 1) ? 24'h0000FF : (n == 2) ? 24'h00FFFF : 24'hFFFFFF;
  endfunction

  // monitor and peripheral responder, sampled between clock edges
  int cyc = 0, cur_n = 1, nfall = 0, xfer_cnt = 0, last_nfall = 0;
  int t_csfall = 0, t_rise = 0, t_fall = 0, hw = 0, idx = 0;
  int v_css = 0, v_hi = 0, v_lo = 0, v_lox = 0, v_gap = 0, v_rdw = 0, v_csh = 0, v_hold = 0, v_idle = 0;
  logic [23:0] resp_cur = '0;
  logic [31:0] cap = '0, last_cap = '0;
  logic [7:0] cmd_r = '0;
  logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_mosi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        t_csfall = cyc; t_rise = cyc; nfall = 0; cap = '0; cmd_r = '0; miso = 1'b0;
        v_css = 0; v_hi = 0; v_lo = 0; v_lox = 0; v_gap = 0; v_rdw = 0; v_csh = 0; v_hold = 0;
      end
      if (!cs_n && prev_sclk && !sclk) begin
        cap = {cap[30:0], mosi};
        if (mosi != prev_mosi) v_hold++;
        hw = cyc - t_rise;
        if (hw < X_HI) v_hi++;
        if (nfall == 0 && (cyc - t_csfall) < X_CSS) v_css++;
        if (nfall == 8 && !cmd_r[7]) begin
          if (hw < X_RDW) v_rdw++;
        end else if (nfall > 0 && (nfall % 8) == 0) begin
          if (hw < (cmd_r[7] ? X_WG : X_RG)) v_gap++;
        end
        nfall++;
        if (nfall == 8) cmd_r = cap[7:0];
        t_fall = cyc;
      end else if (!cs_n && !prev_sclk && !sclk && mosi != prev_mosi) v_hold++;
      if (!cs_n && !prev_sclk && sclk) begin
        if ((cyc - t_fall) < X_LO) v_lo++;
        if ((cyc - t_fall) != X_LO) v_lox++;
        t_rise = cyc;
        if (nfall >= 8 && !cmd_r[7]) begin
          idx = nfall - 8;
          miso = (idx < 8 * cur_n) ? resp_cur[8 * cur_n - 1 - idx] : 1'b0;
        end
      end
      if (!prev_cs && cs_n) begin
        if ((cyc - t_fall) < X_CSH) v_csh++;
        last_cap = cap; last_nfall = nfall; xfer_cnt++;
      end
      if (cs_n && !sclk) v_idle++;
    end
    prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
  end

  task automatic launch(input logic w, input logic [5:0] a, input logic [1:0] n, input logic [23:0] d);
    cur_n = (n == 2'd0) ? 1 : int'(n);
    resp_cur = resp_of(a);
    @(negedge clk); wr = w; addr = a; nbytes = n; wdata = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_xfer(output logic [23:0] rd);
    while (!done) @(negedge clk);
    rd = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'h0);
    chk(busy == 1'b0, "R10 idle after done", 32'(busy), 32'h0);
  endtask

  task automatic timing_checks(input logic w);
    chk(v_css == 0 && v_csh == 0, "R5 chip select setup/hold", 32'(v_css + v_csh), 32'h0);
    chk(v_hi == 0 && v_lo == 0, "R6 clock high/low width", 32'(v_hi + v_lo), 32'h0);
    chk(v_lox == 0, "R12 low phase exact rounded count", 32'(v_lox), 32'h0);
    chk(v_gap == 0, "R8 inter-byte gap", 32'(v_gap), 32'h0);
    chk(v_hold == 0, "R3 data changes only at rising edge", 32'(v_hold), 32'h0);
    if (!w) chk(v_rdw == 0, "R7 read wait after command", 32'(v_rdw), 32'h0);
  endtask

  task automatic do_vec(input logic w, input logic [5:0] a, input logic [1:0] n, input logic [23:0] d);
    logic [23:0] rd;
    logic [31:0] exp_frame;
    int en;
    en = (n == 2'd0) ? 1 : int'(n);
    launch(w, a, n, d);
    chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'h1);
    finish_xfer(rd);
    chk(last_nfall == 8 * (1 + en), "R2 bit count (R11 when zero)", 32'(last_nfall), 32'(8 * (1 + en)));
    chk((last_cap >> (8 * en)) == {24'h0, w, 1'b0, a}, "R1 command byte",
        last_cap >> (8 * en), {24'h0, w, 1'b0, a});
    if (w) begin
      exp_frame = ({24'h0, w, 1'b0, a} << (8 * en)) | {8'h0, d & mask_of(en)};
      chk(last_cap == exp_frame, "R2 write frame", last_cap, exp_frame);
      chk(rd == 24'h0, "R4 rdata zero after write", {8'h0, rd}, 32'h0);
    end else begin
      chk(rd == (resp_of(a) & mask_of(en)), "R4 read result right-aligned",
          {8'h0, rd}, {8'h0, resp_of(a) & mask_of(en)});
    end
    timing_checks(w);
  endtask

  localparam logic [32:0] VEC [6] = '{
    {1'b1, 6'h15, 2'd1, 24'h0000A5},
    {1'b1, 6'h3F, 2'd3, 24'hC35A81},
    {1'b0, 6'h00, 2'd1, 24'h000000},
    {1'b0, 6'h2A, 2'd2, 24'h000000},
    {1'b0, 6'h3F, 2'd3, 24'h000000},
    {1'b1, 6'h01, 2'd2, 24'h127EFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] rd;
    int xc;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R9 reset idle lines", {30'h0, cs_n, sclk}, 32'h3);
    chk(busy == 1'b0 && done == 1'b0 && rdata == 24'h0, "R10 reset handshake",
        {7'h0, busy, done, rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [32:0] v;
      v = VEC[i];
      do_vec(v[32], v[31:26], v[25:24], v[23:0]);
    end

    // R11: byte count zero on both directions
    do_vec(1'b1, 6'h0B, 2'd0, 24'hFFFF5C);
    do_vec(1'b0, 6'h33, 2'd0, 24'h0);

    // R10: start raised mid-access must be ignored
    xc = xfer_cnt;
    launch(1'b1, 6'h05, 2'd1, 24'h00003C);
    repeat (40) @(negedge clk);
    chk(cs_n == 1'b0, "R9 chip select low during access", 32'(cs_n), 32'h0);
    wr = 1'b0; addr = 6'h09; nbytes = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_xfer(rd);
    chk(last_cap == 32'h0000853C, "R10 busy start left frame intact", last_cap, 32'h0000853C);
    repeat (60) @(negedge clk);
    chk(xfer_cnt == xc + 1 && cs_n == 1'b1, "R10 busy start not queued",
        32'(xfer_cnt - xc), 32'h1);
    chk(v_idle == 0, "R9 clock high while deselected", 32'(v_idle), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule